// File: doc/BRIEF.md
# Banked GPIO Register Block

This block gives a processor word-addressed register access to 128 general-purpose pins, grouped as four banks of 32. Pin n belongs to bank n>>5 at bit position n&31. Each bank has a direction mask, an output latch, a level view, and two words of alternate-function storage. The latch never takes a written value directly. Software changes it only through two write registers per bank: one sets every bit written as 1, and the other clears every bit written as 1. Pins are driven only where the direction bit is 1.

Requests arrive on a valid/ready channel. A read returns its data on a registered response channel. A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. A read produces a response one cycle after it is accepted, and a write produces no response. There is a single response slot, so `req_ready` drops while a response is held with `rsp_ready` low. While it is held, `rsp_valid` and `rsp_data` stay stable. Each accepted read of a level register raises `rd_notify` for one cycle, at the same time as its response first appears. Pin inputs are asynchronous and pass through two flops before a level read can see them.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every direction bit, latch bit, alternate-function word and last-set word is 0. `pin_oe` and `pin_out` are 0, `rsp_valid` and `rd_notify` are low, and a direction read returns 0.
- R2: A write to a bank's set register (byte offsets 0x018, 0x01C, 0x020, 0x118 for banks 0..3) ORs the write data into that bank's latch.
- R3: A write to a bank's clear register (0x024, 0x028, 0x02C, 0x124) clears every latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: `pin_oe` equals the direction mask, where 1 means output. The direction registers are at 0x00C, 0x010, 0x014 and 0x10C. `pin_out` equals latch AND direction. Both change on the edge that accepts the write.
- R5: A read of a level register (0x000, 0x004, 0x008, 0x100) returns (latch AND dir) OR (synchronized input AND NOT dir). An input change reaches the level view within three clock edges.
- R6: A read of a set register returns the last value written to it. A read of a clear register returns the decimal constant 31337.
- R7: The alternate-function words are plain read/write storage. The lower words are at 0x054, 0x05C, 0x064, 0x06C and the upper words at 0x058, 0x060, 0x068, 0x070, for banks 0..3.
- R8: A write at an offset of 0x200 or above, or at an unmapped offset below 0x200, changes no register and no pin. A read at any of these offsets returns 0.
- R9: `rd_notify` is high for exactly one cycle per accepted level read, aligned with the first cycle of that response. No other read asserts it.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid` and `rsp_data` hold their values.
- R11: Bank 3 registers sit 0x100 above the bank 0 register of the same kind. Accesses to bank 3 do not disturb banks 0..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | 32 | Read data |
| rd_notify | output | 1 | One-cycle strobe for a level read |
| pin_in | input | 128 | Asynchronous pin inputs |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Per-pin output enable |

## Verification
The assertions assume that the requester keeps `req_write`, `req_addr` and `req_wdata` stable while `req_valid` is high and not yet accepted. They also assume that `rsp_ready` is a clean level that changes only away from the clock edge. The bench drives every request and `rsp_ready` at the falling edge and holds each request until it sees `req_ready` high. It changes `pin_in` only between transfers and waits more than the synchronizer depth before reading a level, so no level read samples an input in transit.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  localparam int NBANK      = 4;
  localparam int PINS_PER   = 32;
  localparam int NPIN       = NBANK * PINS_PER;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = PINS_PER;
  localparam int BANK_W     = $clog2(NBANK);
  localparam int WINDOW     = 'h200;
  localparam int HIGH_STEP  = 'h100;
  localparam logic [DATA_W-1:0] CLR_READ_VAL = 32'd31337;

  localparam int OFS_LEVEL  = 'h000;
  localparam int OFS_DIR    = 'h00C;
  localparam int OFS_SET    = 'h018;
  localparam int OFS_CLR    = 'h024;
  localparam int OFS_ALT    = 'h054;

  typedef enum logic [2:0] {
    RK_NONE, RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_ALT_LO, RK_ALT_HI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [BANK_W-1:0] bank;
  } reg_sel_t;

  // The last bank of a grouped register kind lives HIGH_STEP above bank 0.
  function automatic int grp_off(input int b);
    return (b == NBANK - 1) ? HIGH_STEP : 4 * b;
  endfunction

  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] addr);
    reg_sel_t s;
    int wa;
    s.kind = RK_NONE;
    s.bank = '0;
    wa = int'({addr[ADDR_W-1:2], 2'b00});
    if (wa < WINDOW) begin
      for (int b = 0; b < NBANK; b++) begin
        if (wa == OFS_LEVEL + grp_off(b)) begin s.kind = RK_LEVEL;  s.bank = BANK_W'(b); end
        if (wa == OFS_DIR   + grp_off(b)) begin s.kind = RK_DIR;    s.bank = BANK_W'(b); end
        if (wa == OFS_SET   + grp_off(b)) begin s.kind = RK_SET;    s.bank = BANK_W'(b); end
        if (wa == OFS_CLR   + grp_off(b)) begin s.kind = RK_CLR;    s.bank = BANK_W'(b); end
        if (wa == OFS_ALT + 8 * b)        begin s.kind = RK_ALT_LO; s.bank = BANK_W'(b); end
        if (wa == OFS_ALT + 8 * b + 4)    begin s.kind = RK_ALT_HI; s.bank = BANK_W'(b); end
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_rb_bank.sv
module gpio_rb_bank
  import gpio_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] in_sync,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] set_last_q,
  output logic [DATA_W-1:0] alt_lo_q,
  output logic [DATA_W-1:0] alt_hi_q,
  output logic [DATA_W-1:0] level
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q      <= '0;
      latch_q    <= '0;
      set_last_q <= '0;
      alt_lo_q   <= '0;
      alt_hi_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_kind)
        RK_DIR:    dir_q <= wr_data;
        RK_SET: begin
          latch_q    <= latch_q | wr_data;
          set_last_q <= wr_data;
        end
        RK_CLR:    latch_q  <= latch_q & ~wr_data;
        RK_ALT_LO: alt_lo_q <= wr_data;
        RK_ALT_HI: alt_hi_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign level = (latch_q & dir_q) | (in_sync & ~dir_q);
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rd_notify,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  logic [NPIN-1:0]   pin_sync;
  reg_sel_t          sel;
  logic              accept;
  logic [DATA_W-1:0] rd_mux;

  logic [DATA_W-1:0] dir_b   [NBANK];
  logic [DATA_W-1:0] latch_b [NBANK];
  logic [DATA_W-1:0] setl_b  [NBANK];
  logic [DATA_W-1:0] altl_b  [NBANK];
  logic [DATA_W-1:0] alth_b  [NBANK];
  logic [DATA_W-1:0] lvl_b   [NBANK];

  gpio_rb_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync)
  );

  assign sel       = decode(req_addr);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_rb_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (accept && req_write && sel.bank == BANK_W'(b)),
      .wr_kind   (sel.kind),
      .wr_data   (req_wdata),
      .in_sync   (pin_sync[b*PINS_PER +: PINS_PER]),
      .dir_q     (dir_b[b]),
      .latch_q   (latch_b[b]),
      .set_last_q(setl_b[b]),
      .alt_lo_q  (altl_b[b]),
      .alt_hi_q  (alth_b[b]),
      .level     (lvl_b[b])
    );
    assign pin_oe [b*PINS_PER +: PINS_PER] = dir_b[b];
    assign pin_out[b*PINS_PER +: PINS_PER] = latch_b[b] & dir_b[b];
  end

  always_comb begin
    unique case (sel.kind)
      RK_LEVEL:  rd_mux = lvl_b[sel.bank];
      RK_DIR:    rd_mux = dir_b[sel.bank];
      RK_SET:    rd_mux = setl_b[sel.bank];
      RK_CLR:    rd_mux = CLR_READ_VAL;
      RK_ALT_LO: rd_mux = altl_b[sel.bank];
      RK_ALT_HI: rd_mux = alth_b[sel.bank];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rd_notify <= 1'b0;
    end else begin
      rd_notify <= 1'b0;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
        rd_notify <= (sel.kind == RK_LEVEL);
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rd_notify,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe
);
  logic wr_acc;
  assign wr_acc = req_valid && req_ready && req_write;

  a_r4_out_within_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r2_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && {req_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(OFS_SET)) |=>
    ((pin_out[PINS_PER-1:0] & $past(req_wdata)) == (pin_oe[PINS_PER-1:0] & $past(req_wdata))));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && {req_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(OFS_CLR)) |=>
    ((pin_out[PINS_PER-1:0] & $past(req_wdata)) == '0));

  a_r8_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && int'(req_addr) >= WINDOW) |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r9_notify_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_notify |-> rsp_valid);

  a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind gpio_regbank gpio_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rd_notify(rd_notify), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_data;
  logic         rd_notify;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out;
  logic [127:0] pin_oe;

  int checks = 0;
  int errors = 0;
  int notify_seen = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  gpio_regbank uut (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(bit we, logic [11:0] a, logic [31:0] d, logic [31:0] exp, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (!we) begin exp_q.push_back(exp); tag_q.push_back(req); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pop expected read data whenever a response is taken.
  always @(negedge clk) begin
    if (rst_n && rd_notify) notify_seen++;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual unexpected response %h expected none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {96'd0, rsp_data}, {96'd0, e});
      end
    end
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 rsp_valid", {127'd0, rsp_valid}, 128'd0);
    rst_n = 1'b1;
    xfer(0, 12'h00C, 0, 32'h0, "R1 dir read");
    xfer(0, 12'h118, 0, 32'h0, "R1 set-last read");

    // Direction and set on bank 0
    xfer(1, 12'h00C, 32'h0000_FFFF, 0, "");
    xfer(1, 12'h018, 32'h00FF_00FF, 0, "");
    check("R4 pin_oe bank0", pin_oe, 128'h0000_FFFF);
    check("R2 pin_out after set", pin_out, 128'h0000_00FF);
    xfer(1, 12'h024, 32'h0000_000F, 0, "");
    check("R3 pin_out after clear", pin_out, 128'h0000_00F0);

    // Level merge
    pin_in = {32'h0, 32'h0, 32'h0, 32'hA5A5_5A5A};
    repeat (4) @(negedge clk);
    xfer(0, 12'h000, 0, 32'hA5A5_00F0, "R5 level bank0");
    // Enable more outputs: hidden latch bits 16..23 appear
    xfer(1, 12'h00C, 32'h00FF_FFFF, 0, "");
    check("R4 latch bits now driven", pin_out, 128'h00FF_00F0);
    xfer(0, 12'h000, 0, 32'hA5FF_00F0, "R5 level after dir change");

    // Bank 3
    xfer(1, 12'h10C, 32'hFFFF_FFFF, 0, "");
    xfer(1, 12'h118, 32'h8000_0001, 0, "");
    check("R11 bank3 pins", pin_out[127:96], 128'h8000_0001);
    check("R11 banks 1,2 untouched", pin_out[95:32], '0);
    xfer(0, 12'h100, 0, 32'h8000_0001, "R11 level bank3");
    xfer(1, 12'h124, 32'h8000_0000, 0, "");
    check("R3 bank3 clear", pin_out[127:96], 128'h0000_0001);
    check("R11 bank0 kept", pin_out[31:0], 128'h00FF_00F0);

    // Read-back of write registers
    xfer(0, 12'h018, 0, 32'h00FF_00FF, "R6 set-last bank0");
    xfer(0, 12'h118, 0, 32'h8000_0001, "R6 set-last bank3");
    xfer(0, 12'h028, 0, 32'd31337, "R6 clear read constant");

    // Alternate-function storage
    xfer(1, 12'h06C, 32'h1234_5678, 0, "");
    xfer(1, 12'h070, 32'hCAFE_F00D, 0, "");
    xfer(1, 12'h054, 32'h0000_0001, 0, "");
    xfer(0, 12'h06C, 0, 32'h1234_5678, "R7 alt lo bank3");
    xfer(0, 12'h070, 0, 32'hCAFE_F00D, "R7 alt hi bank3");
    xfer(0, 12'h054, 0, 32'h0000_0001, "R7 alt lo bank0");
    xfer(0, 12'h05C, 0, 32'h0, "R7 alt lo bank1");

    // Ignored offsets
    xfer(1, 12'h218, 32'hFFFF_FFFF, 0, "");
    xfer(1, 12'h30C, 32'hFFFF_FFFF, 0, "");
    xfer(1, 12'h0FC, 32'hFFFF_FFFF, 0, "");
    check("R8 pins unchanged", pin_out, {32'h0000_0001, 64'h0, 32'h00FF_00F0});
    check("R8 oe unchanged", pin_oe, {32'hFFFF_FFFF, 64'h0, 32'h00FF_FFFF});
    xfer(0, 12'h200, 0, 32'h0, "R8 read above window");
    xfer(0, 12'h0FC, 0, 32'h0, "R8 unmapped read");
    xfer(0, 12'h018, 0, 32'h00FF_00FF, "R8 set-last not aliased");

    // Notify: three level reads so far, none from other reads
    repeat (2) @(negedge clk);
    check("R9 notify count", notify_seen, 3);
    xfer(0, 12'h004, 0, 32'h0, "R5 level bank1");
    repeat (2) @(negedge clk);
    check("R9 notify count after bank1 level", notify_seen, 4);

    // Back-pressure
    rsp_ready = 1'b0;
    xfer(0, 12'h008, 0, 32'h0, "R10 held level bank2");
    check("R10 req_ready low", {127'd0, req_ready}, 128'd0);
    check("R10 rsp_valid held", {127'd0, rsp_valid}, 128'd1);
    repeat (3) @(negedge clk);
    check("R10 still held", {127'd0, rsp_valid}, 128'd1);
    check("R9 single notify pulse", notify_seen, 5);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule